// File: doc/BRIEF.md
# Two-Stage Serial Bit-Clock Divider

This block derives the bit clock of a synchronous serial port from the system clock. It uses two programmable divide stages in series. The first stage is an 8-bit prescale value that software writes through a small register port. That value can only be even: bit 0 is dropped on write and reads back as zero. The second stage is a rate field that comes from a separate control input. It divides by one more than its value. The output clock period is therefore prescale × (1 + rate) system cycles.

The prescale register is double-buffered. A write lands in a holding stage, which the register port reads back. The divide engine copies the holding value and the rate input into its active setting while it is stopped. While it is running, it copies them only when a full output period has completed.

Both the holding stage and the active setting clear on reset. The output clock therefore stays low until software writes a nonzero prescale value and raises the enable. The output clock always has a 50 % duty cycle. Alongside it, a one-cycle tick marks each rising edge, for use by a shift engine.

Top module: `serclk_prescaler`

## Requirements
- R1: After synchronous reset, `sclk_out` and `bit_tick` are low and `reg_rdata` reads 0x0000.
- R2: A write with `reg_wr` high stores `reg_wdata[7:1]` in the holding stage. From the next cycle, `reg_rdata` returns that value in bits 7:1, with bit 0 and bits 15:8 reading zero, whatever was written there.
- R3: While running with prescale P and rate R, `sclk_out` is high for exactly P×(1+R)/2 cycles and then low for exactly P×(1+R)/2 cycles.
- R4: `bit_tick` is high for exactly one cycle per output period. That cycle is the first cycle in which `sclk_out` is high.
- R5: While the active prescale value is zero, `sclk_out` and `bit_tick` stay low, even with `enable` high.
- R6: If `enable` is low at a clock edge, `sclk_out` and `bit_tick` are low after that edge.
- R7: While running, a new prescale write or rate change takes effect only at the falling edge of `sclk_out` that ends the current high phase. Periods run low phase then high phase, so the high phase in progress keeps its old length.
- R8: Let H be P×(1+R)/2, using the holding stage and rate loaded while stopped. Once `enable` is high, `sclk_out` first rises after the H-th clock edge. That edge is counted from the first edge at which `enable` is high.

Periods run low phase then high phase; the first low phase described in R8 is a full half period of H cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe for the prescale register |
| reg_wdata | input | 16 | Write data; bits 7:1 hold the prescale value divided by two |
| reg_rdata | output | 16 | Holding-stage readback |
| rate | input | 8 | Second-stage rate value R; that stage divides by 1 + R |
| enable | input | 1 | Run enable |
| sclk_out | output | 1 | Serial bit clock |
| bit_tick | output | 1 | One-cycle pulse on each rising edge of `sclk_out` |

## Verification
A wrong count or an unreloaded active setting shows at the ports as a phase whose length differs from P×(1+R)/2. The very next half period of `sclk_out` exposes it. A setting copied too early shows up within the phase in progress: a high phase cut short or stretched right after a mid-period write. A stuck tick or enable path shows within one cycle, as a tick with no rising edge or a clock still high after `enable` drops.

// File: rtl/sclk_pkg.sv
package sclk_pkg;

    // Default geometry of the divider.
    localparam int unsigned REG_W  = 16;
    localparam int unsigned PSR_W  = 8;
    localparam int unsigned RATE_W = 8;

    // Phase of the generated clock.
    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } sclk_phase_e;

    // Running state of the divide engine.
    typedef struct packed {
        sclk_phase_e phase;
        logic        tick;
    } sclk_out_t;

endpackage

// File: rtl/sclk_psr_hold.sv
module sclk_psr_hold #(
    parameter int unsigned REG_W = 16,
    parameter int unsigned PSR_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [PSR_W-1:0] wdata,
    output logic [PSR_W-2:0] half_q,
    output logic [REG_W-1:0] rdata
);
    localparam int unsigned PAD_W = REG_W - PSR_W;

    // Holding stage: only the even part of the prescale value is kept.
    always_ff @(posedge clk) begin
        if (rst) begin
            half_q <= '0;
        end else if (wr) begin
            half_q <= wdata[PSR_W-1:1];
        end
    end

    wire unused_lsb = wdata[0];

    generate
        if (PAD_W > 0) begin : g_pad
            assign rdata = {{PAD_W{1'b0}}, half_q, 1'b0};
        end else begin : g_nopad
            assign rdata = {half_q, 1'b0};
        end
    endgenerate
endmodule

// File: rtl/sclk_div_core.sv
module sclk_div_core
    import sclk_pkg::*;
#(
    parameter int unsigned PSR_W  = 8,
    parameter int unsigned RATE_W = 8,
    parameter int unsigned CNT_W  = PSR_W + RATE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic [PSR_W-2:0]  hold_half,
    input  logic [RATE_W-1:0] rate,
    output sclk_out_t         out_q,
    output logic [CNT_W-1:0]  len_q,
    output logic [CNT_W-1:0]  cnt_q
);
    logic [CNT_W-1:0] next_len;
    logic             run;
    logic             at_end;

    // Half period = (P/2) * (1 + R), computed once per reload.
    assign next_len = CNT_W'(hold_half) * (CNT_W'(rate) + CNT_W'(1));
    assign run      = enable && (len_q != '0);
    assign at_end   = (cnt_q == len_q - CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            len_q       <= '0;
            cnt_q       <= '0;
            out_q.phase <= PH_LOW;
            out_q.tick  <= 1'b0;
        end else if (!run) begin
            len_q       <= next_len;
            cnt_q       <= '0;
            out_q.phase <= PH_LOW;
            out_q.tick  <= 1'b0;
        end else begin
            out_q.tick <= 1'b0;
            if (at_end) begin
                cnt_q <= '0;
                if (out_q.phase == PH_LOW) begin
                    out_q.phase <= PH_HIGH;
                    out_q.tick  <= 1'b1;
                end else begin
                    out_q.phase <= PH_LOW;
                    len_q       <= next_len;
                end
            end else begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/serclk_prescaler.sv
module serclk_prescaler
    import sclk_pkg::*;
#(
    parameter int unsigned REG_W  = sclk_pkg::REG_W,
    parameter int unsigned PSR_W  = sclk_pkg::PSR_W,
    parameter int unsigned RATE_W = sclk_pkg::RATE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic [RATE_W-1:0] rate,
    input  logic              enable,
    output logic              sclk_out,
    output logic              bit_tick
);
    localparam int unsigned CNT_W = PSR_W + RATE_W;

    logic [PSR_W-2:0] hold_half;
    logic [CNT_W-1:0] core_len;
    logic [CNT_W-1:0] core_cnt;
    sclk_out_t        core_out;

    wire unused_hi = ^reg_wdata[REG_W-1:PSR_W];

    sclk_psr_hold #(.REG_W(REG_W), .PSR_W(PSR_W)) u_hold (
        .clk    (clk),
        .rst    (rst),
        .wr     (reg_wr),
        .wdata  (reg_wdata[PSR_W-1:0]),
        .half_q (hold_half),
        .rdata  (reg_rdata)
    );

    sclk_div_core #(.PSR_W(PSR_W), .RATE_W(RATE_W), .CNT_W(CNT_W)) u_core (
        .clk       (clk),
        .rst       (rst),
        .enable    (enable),
        .hold_half (hold_half),
        .rate      (rate),
        .out_q     (core_out),
        .len_q     (core_len),
        .cnt_q     (core_cnt)
    );

    assign sclk_out = (core_out.phase == PH_HIGH);
    assign bit_tick = core_out.tick;
endmodule

// File: rtl/sclk_prescaler_chk.sv
module sclk_prescaler_chk #(
    parameter int unsigned REG_W = 16,
    parameter int unsigned PSR_W = 8,
    parameter int unsigned CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             reg_wr,
    input logic [REG_W-1:0] reg_wdata,
    input logic [REG_W-1:0] reg_rdata,
    input logic             enable,
    input logic             sclk_out,
    input logic             bit_tick,
    input logic [CNT_W-1:0] len,
    input logic [CNT_W-1:0] cnt
);
    localparam logic [REG_W-1:0] KEEP = REG_W'((1 << PSR_W) - 2);

    // R2: readback never shows bit 0 or the reserved upper bits
    always_comb begin
        if (!rst) begin
            p_rdata_even_r2: assert ((reg_rdata & ~KEEP) == '0);
        end
    end

    // R2: a write is visible in the next cycle
    p_write_read_r2: assert property (@(posedge clk) disable iff (rst)
        reg_wr |=> (reg_rdata == ($past(reg_wdata) & KEEP)));

    // R4: tick only on the first high cycle
    p_tick_rise_r4: assert property (@(posedge clk) disable iff (rst)
        bit_tick |-> (sclk_out && !$past(sclk_out)));

    // R4: every rise carries a tick
    p_rise_tick_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(sclk_out) |-> bit_tick);

    // R6: disabling forces the outputs low
    p_idle_low_r6: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (!sclk_out && !bit_tick));

    // R5: zero divisor keeps the clock stopped
    p_zero_stop_r5: assert property (@(posedge clk) disable iff (rst)
        (len == '0) |=> !$rose(sclk_out));

    // R3: the counter stays inside the half period
    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
        (len != '0) |-> (cnt < len));
endmodule

bind serclk_prescaler sclk_prescaler_chk #(
    .REG_W(REG_W), .PSR_W(PSR_W), .CNT_W(PSR_W + RATE_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .enable    (enable),
    .sclk_out  (sclk_out),
    .bit_tick  (bit_tick),
    .len       (core_len),
    .cnt       (core_cnt)
);

// File: tb/test_serclk_prescaler.sv
module test_serclk_prescaler;
    logic        clk = 1'b0;
    logic        rst;
    logic        reg_wr;
    logic [15:0] reg_wdata;
    logic [15:0] reg_rdata;
    logic [7:0]  rate;
    logic        enable;
    logic        sclk_out;
    logic        bit_tick;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    serclk_prescaler i_serclk_prescaler (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .rate(rate), .enable(enable),
        .sclk_out(sclk_out), .bit_tick(bit_tick)
    );

    // {write data, rate, expected readback, expected half period}
    localparam int NV = 7;
    localparam logic [55:0] VEC [NV] = '{
        {16'h0002, 8'd0,   16'h0002, 16'd1},
        {16'h0005, 8'd2,   16'h0004, 16'd6},
        {16'h000A, 8'd1,   16'h000A, 16'd10},
        {16'h00FE, 8'd3,   16'h00FE, 16'd508},
        {16'hFF07, 8'd4,   16'h0006, 16'd15},
        {16'h0002, 8'd255, 16'h0002, 16'd256},
        {16'h0013, 8'd0,   16'h0012, 16'd9}
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic [15:0] d);
        @(negedge clk);
        reg_wr    = 1'b1;
        reg_wdata = d;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    // Counts negedges while sclk_out equals lvl.
    task automatic count_level(input logic lvl, output int n);
        n = 0;
        while (sclk_out == lvl && n < 70000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic start_and_count(output int n);
        n = 0;
        @(negedge clk);
        enable = 1'b1;
        do begin
            @(negedge clk);
            n++;
        end while (!sclk_out && n < 70000);
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int n;
        int hi;
        int lo;
        int seen;
        rst = 1'b1; reg_wr = 1'b0; reg_wdata = '0; rate = '0; enable = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 sclk", int'(sclk_out), 0);
        check("R1 tick", int'(bit_tick), 0);
        check("R1 rdata", int'(reg_rdata), 0);

        // R5: zero prescale, enabled, nothing toggles
        rate = 8'd5; enable = 1'b1;
        seen = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (sclk_out || bit_tick) seen++;
        end
        check("R5 stopped with zero divisor", seen, 0);
        enable = 1'b0;

        // Vector walk: R2, R8, R3, R4
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            enable = 1'b0;
            rate = VEC[v][39:32];
            write_reg(VEC[v][55:40]);
            check("R2 readback", int'(reg_rdata), int'(VEC[v][31:16]));
            @(negedge clk);
            start_and_count(n);
            check("R8 startup delay", n, int'(VEC[v][15:0]));
            check("R4 tick at rise", int'(bit_tick), 1);
            count_level(1'b1, hi);
            check("R3 high phase", hi, int'(VEC[v][15:0]));
            count_level(1'b0, lo);
            check("R3 low phase", lo, int'(VEC[v][15:0]));
            // one full high phase, counting ticks
            seen = 0;
            n = 0;
            while (sclk_out && n < 70000) begin
                if (bit_tick) seen++;
                n++;
                @(negedge clk);
            end
            check("R4 single tick per period", seen, 1);
        end

        // R6: disable mid high phase
        @(negedge clk);
        enable = 1'b0;
        rate = 8'd1;
        write_reg(16'h000A);
        @(negedge clk);
        start_and_count(n);
        @(negedge clk);
        @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        check("R6 sclk low after disable", int'(sclk_out), 0);
        seen = 0;
        for (int i = 0; i < 30; i++) begin
            if (sclk_out || bit_tick) seen++;
            @(negedge clk);
        end
        check("R6 stays low while disabled", seen, 0);

        // R7: change during high phase of H=4, new H=12
        rate = 8'd0;
        write_reg(16'h0008);
        @(negedge clk);
        start_and_count(n);
        rate = 8'd1;
        write_reg(16'h000C);
        count_level(1'b1, hi);
        check("R7 current high keeps old length", hi + 2, 4);
        count_level(1'b0, lo);
        check("R7 next low uses new length", lo, 12);
        count_level(1'b1, hi);
        check("R7 next high uses new length", hi, 12);
        enable = 1'b0;

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule